// File: doc/BRIEF.md
# Time-Slot Data Link Bit Selector

This block sits beside a T1/E1 framer and marks which bit positions of the serial frame belong to a data link channel. The framer supplies its bit-timing strobe, the current slot number, the bit index within the slot and a flag for the T1 framing-bit position. From these inputs and a small set of configuration inputs, the block decides whether the current bit is a link bit.

On the receive side, each selected bit appears one clock later on a single-cycle strobe, together with the sampled data. On the transmit side, a request is raised in the same cycle as the selected bit. The link source's bit is then muxed onto the outgoing line in place of the framer's bit.

A 5-bit slot code chooses the slot. Code zero has a meaning that depends on the format. In T1 it selects the framing bit of every frame, and the per-bit mask is not used. In E1 it selects slot 0 like any other slot. Receive and transmit are enabled separately.

Top module: `tsdl_bit_sel`

## Requirements
- R1: For a slot code from 1 to 31, a bit is selected only when `slot_i` equals the code and the mask bit for that bit position is 1.
- R2: In E1 format (`fmt_e1_i`=1), slot code 0 selects slot 0 and is subject to the mask, the same as any other slot.
- R3: In T1 format (`fmt_e1_i`=0), slot code 0 selects every bit flagged by `fbit_i`, whatever the mask holds, and selects no payload bit.
- R4: Mask bit n enables bit position n of the slot, where `bitpos_i`=0 is the first bit on the line and 7 is the eighth. Any combination of mask bits is allowed.
- R5: `rx_strobe_o` rises for exactly one cycle, in the cycle after a selected bit, and `rx_bit_o` then holds that bit's `rx_data_i`. `rx_bit_o` keeps its value while no strobe is given.
- R6: While `rx_en_i` is 0, `rx_strobe_o` stays 0.
- R7: `tx_req_o` is high in the same cycle as a selected bit when `tx_en_i`=1. While it is high, `tx_line_o` equals `tx_link_i`; otherwise `tx_line_o` equals `tx_line_i`.
- R8: While `tx_en_i` is 0, `tx_req_o` is 0 and `tx_line_o` equals `tx_line_i`.
- R9: No bit is selected in a cycle where `bit_valid_i` is 0, even when slot and position match.
- R10: In T1 format with a nonzero slot code, a bit flagged by `fbit_i` is never selected. In E1 format, `fbit_i` has no effect.
- R11: While `rst_ni` is low, `rx_strobe_o` and `rx_bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_e1_i | input | 1 | Frame format: 0 = T1 (193 bits), 1 = E1 (256 bits) |
| slot_code_i | input | 5 | Slot select code |
| bit_mask_i | input | 8 | Per-bit enable mask for the chosen slot |
| rx_en_i | input | 1 | Receive link enable |
| tx_en_i | input | 1 | Transmit link enable |
| bit_valid_i | input | 1 | Framer bit-timing strobe, one line bit per high cycle |
| fbit_i | input | 1 | Current bit is the T1 framing bit |
| slot_i | input | 5 | Current slot number from the framer |
| bitpos_i | input | 3 | Bit index within the slot, 0 = first on the line |
| rx_data_i | input | 1 | Received serial bit |
| tx_line_i | input | 1 | Outgoing bit from the framer |
| tx_link_i | input | 1 | Link bit to insert |
| rx_strobe_o | output | 1 | One-cycle strobe for a captured link bit |
| rx_bit_o | output | 1 | Captured link bit |
| tx_req_o | output | 1 | Current bit is taken by the link |
| tx_line_o | output | 1 | Outgoing bit after insertion |

## Verification
The hardest case to reach is a cycle where slot and bit position match but `bit_valid_i` is low. A free-running framer never produces it. The stimulus therefore inserts idle cycles at random that repeat the previous bit's slot and position with the strobe deasserted. It also raises `fbit_i` on random E1 bits to confirm the flag has no effect there. The T1 framing-bit case is run with an all-zero mask, so any use of the mask shows up as a missing strobe in the scoreboard.

// File: rtl/tsdl_pkg.sv
package tsdl_pkg;
  typedef enum logic {
    FMT_T1 = 1'b0,
    FMT_E1 = 1'b1
  } frame_fmt_e;

  localparam int unsigned SLOT_W   = 5;
  localparam int unsigned SLOT_BITS = 8;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
  } dir_en_t;
endpackage

// File: rtl/tsdl_slot_match.sv
module tsdl_slot_match
  import tsdl_pkg::*;
#(
  parameter int unsigned SW = SLOT_W,
  parameter int unsigned NB = SLOT_BITS,
  localparam int unsigned BW = $clog2(NB)
) (
  input  frame_fmt_e       fmt_i,
  input  logic [SW-1:0]    code_i,
  input  logic [NB-1:0]    mask_i,
  input  logic             valid_i,
  input  logic             fbit_i,
  input  logic [SW-1:0]    slot_i,
  input  logic [BW-1:0]    bitpos_i,
  output logic             hit_o
);
  logic [NB-1:0] pos_sel;
  logic          pos_hit;
  logic          fbit_mode;
  logic          fbit_cur;

  for (genvar i = 0; i < NB; i++) begin : g_pos
    assign pos_sel[i] = mask_i[i] & (bitpos_i == BW'(i));
  end
  assign pos_hit = |pos_sel;

  // code 0 in T1 means framing bit; mask unused there
  assign fbit_mode = (fmt_i == FMT_T1) && (code_i == '0);
  assign fbit_cur  = (fmt_i == FMT_T1) && fbit_i;

  always_comb begin
    hit_o = 1'b0;
    if (valid_i) begin
      if (fbit_mode) hit_o = fbit_cur;
      else           hit_o = !fbit_cur && (slot_i == code_i) && pos_hit;
    end
  end
endmodule

// File: rtl/tsdl_rx_tap.sv
module tsdl_rx_tap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic data_i,
  output logic strobe_o,
  output logic bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      strobe_o <= take_i;
      if (take_i) bit_o <= data_i;
    end
  end
endmodule

// File: rtl/tsdl_tx_insert.sv
module tsdl_tx_insert (
  input  logic take_i,
  input  logic line_i,
  input  logic link_i,
  output logic req_o,
  output logic line_o
);
  assign req_o  = take_i;
  assign line_o = take_i ? link_i : line_i;
endmodule

// File: rtl/tsdl_bit_sel.sv
module tsdl_bit_sel
  import tsdl_pkg::*;
#(
  parameter int unsigned SW = SLOT_W,
  parameter int unsigned NB = SLOT_BITS,
  localparam int unsigned BW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fmt_e1_i,
  input  logic [SW-1:0] slot_code_i,
  input  logic [NB-1:0] bit_mask_i,
  input  logic          rx_en_i,
  input  logic          tx_en_i,
  input  logic          bit_valid_i,
  input  logic          fbit_i,
  input  logic [SW-1:0] slot_i,
  input  logic [BW-1:0] bitpos_i,
  input  logic          rx_data_i,
  input  logic          tx_line_i,
  input  logic          tx_link_i,
  output logic          rx_strobe_o,
  output logic          rx_bit_o,
  output logic          tx_req_o,
  output logic          tx_line_o
);
  frame_fmt_e fmt;
  dir_en_t    en;
  logic       hit;

  assign fmt      = frame_fmt_e'(fmt_e1_i);
  assign en.rx_en = rx_en_i;
  assign en.tx_en = tx_en_i;

  tsdl_slot_match #(.SW(SW), .NB(NB)) u_match (
    .fmt_i    (fmt),
    .code_i   (slot_code_i),
    .mask_i   (bit_mask_i),
    .valid_i  (bit_valid_i),
    .fbit_i   (fbit_i),
    .slot_i   (slot_i),
    .bitpos_i (bitpos_i),
    .hit_o    (hit)
  );

  tsdl_rx_tap u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (hit & en.rx_en),
    .data_i   (rx_data_i),
    .strobe_o (rx_strobe_o),
    .bit_o    (rx_bit_o)
  );

  tsdl_tx_insert u_tx (
    .take_i (hit & en.tx_en),
    .line_i (tx_line_i),
    .link_i (tx_link_i),
    .req_o  (tx_req_o),
    .line_o (tx_line_o)
  );
endmodule

// File: rtl/tsdl_bit_sel_chk.sv
module tsdl_bit_sel_chk #(
  parameter int unsigned SW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fmt_e1_i,
  input logic [SW-1:0] slot_code_i,
  input logic          rx_en_i,
  input logic          tx_en_i,
  input logic          bit_valid_i,
  input logic          fbit_i,
  input logic          rx_data_i,
  input logic          tx_line_i,
  input logic          tx_link_i,
  input logic          rx_strobe_o,
  input logic          rx_bit_o,
  input logic          tx_req_o,
  input logic          tx_line_o
);
  assert_fbit_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_e1_i && slot_code_i == '0 && bit_valid_i && fbit_i && tx_en_i) |-> tx_req_o);

  assert_rx_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_strobe_o |-> (rx_bit_o == $past(rx_data_i)));

  assert_rx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_strobe_o |-> $stable(rx_bit_o));

  assert_rx_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_strobe_o);

  assert_tx_ins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (tx_line_o == tx_link_i));

  assert_tx_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> (!tx_req_o && tx_line_o == tx_line_i));

  assert_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |-> !tx_req_o);

  assert_fbit_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_e1_i && slot_code_i != '0 && fbit_i) |-> !tx_req_o);
endmodule

bind tsdl_bit_sel tsdl_bit_sel_chk #(.SW(SW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fmt_e1_i    (fmt_e1_i),
  .slot_code_i (slot_code_i),
  .rx_en_i     (rx_en_i),
  .tx_en_i     (tx_en_i),
  .bit_valid_i (bit_valid_i),
  .fbit_i      (fbit_i),
  .rx_data_i   (rx_data_i),
  .tx_line_i   (tx_line_i),
  .tx_link_i   (tx_link_i),
  .rx_strobe_o (rx_strobe_o),
  .rx_bit_o    (rx_bit_o),
  .tx_req_o    (tx_req_o),
  .tx_line_o   (tx_line_o)
);

// File: tb/tsdl_bit_sel_bench.sv
module tsdl_bit_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       fmt_e1 = 1'b0;
  logic [4:0] code = '0;
  logic [7:0] mask = '0;
  logic       rx_en = 1'b0, tx_en = 1'b0;
  logic       bvalid = 1'b0, fbit = 1'b0;
  logic [4:0] slot = '0;
  logic [2:0] bitpos = '0;
  logic       rx_d = 1'b0, tx_ln = 1'b0, tx_lk = 1'b0;
  logic       rx_stb, rx_bit, tx_req, tx_out;

  tsdl_bit_sel u_tsdl_bit_sel (
    .clk_i(clk), .rst_ni(rst_n), .fmt_e1_i(fmt_e1), .slot_code_i(code),
    .bit_mask_i(mask), .rx_en_i(rx_en), .tx_en_i(tx_en), .bit_valid_i(bvalid),
    .fbit_i(fbit), .slot_i(slot), .bitpos_i(bitpos), .rx_data_i(rx_d),
    .tx_line_i(tx_ln), .tx_link_i(tx_lk), .rx_strobe_o(rx_stb),
    .rx_bit_o(rx_bit), .tx_req_o(tx_req), .tx_line_o(tx_out)
  );

  typedef struct packed { int stamp; logic d; } exp_t;
  exp_t  q[$];
  int    n_vec = 0, n_bad = 0, cyc = 0;
  bit    run = 1'b0;
  logic  last_rx = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic model_hit();
    if (!bvalid) return 1'b0;
    if (!fmt_e1 && code == 5'd0) return fbit;
    if (!fmt_e1 && fbit) return 1'b0;
    return (slot == code) && mask[bitpos];
  endfunction

  // monitor: scoreboard for the receive side
  always @(negedge clk) if (run) begin
    n_vec++;
    if (rx_stb) begin
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL %s/R6: unexpected rx strobe bit=%0b expected no strobe", cur_req, rx_bit);
        last_rx = rx_bit;
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.stamp != cyc - 1 || rx_bit !== e.d) begin
          n_bad++;
          $display("FAIL %s/R5: rx bit=%0b at cyc %0d expected %0b from cyc %0d",
                   cur_req, rx_bit, cyc, e.d, e.stamp + 1);
        end
        last_rx = e.d;
      end
    end else begin
      if (rx_bit !== last_rx) begin
        n_bad++;
        $display("FAIL R5: rx_bit changed without strobe actual %0b expected %0b", rx_bit, last_rx);
        last_rx = rx_bit;
      end
      if (q.size() != 0 && q[0].stamp < cyc) begin
        n_bad++;
        $display("FAIL %s: missing rx strobe actual 0 expected 1 (bit from cyc %0d)", cur_req, q[0].stamp);
        void'(q.pop_front());
      end
    end
  end

  task automatic send_bit(input logic v, input logic fb, input int sl, input int bp);
    logic h, exp_req, exp_ln;
    @(posedge clk); #1;
    bvalid = v; fbit = fb; slot = sl[4:0]; bitpos = bp[2:0];
    rx_d = 1'($urandom); tx_ln = 1'($urandom); tx_lk = 1'($urandom);
    h = model_hit();
    if (h && rx_en) q.push_back('{cyc, rx_d});
    #1;
    exp_req = h && tx_en;
    exp_ln  = exp_req ? tx_lk : tx_ln;
    n_vec++;
    if (tx_req !== exp_req || tx_out !== exp_ln) begin
      n_bad++;
      $display("FAIL %s/R7: tx req/line actual %0b/%0b expected %0b/%0b",
               cur_req, tx_req, tx_out, exp_req, exp_ln);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, 0, 0);
  endtask

  // gaps: insert invalid cycles repeating slot/pos; fnoise: random fbit in E1
  task automatic run_frames(input int nfr, input bit gaps, input bit fnoise);
    for (int f = 0; f < nfr; f++) begin
      if (!fmt_e1) begin
        send_bit(1'b1, 1'b1, 0, 0);
        if (gaps) send_bit(1'b0, 1'b1, 0, 0);
        for (int s = 1; s <= 24; s++)
          for (int b = 0; b < 8; b++) begin
            send_bit(1'b1, 1'b0, s, b);
            if (gaps && ($urandom % 4 == 0)) send_bit(1'b0, 1'b0, s, b);
          end
      end else begin
        for (int s = 0; s < 32; s++)
          for (int b = 0; b < 8; b++) begin
            send_bit(1'b1, fnoise ? 1'($urandom) : 1'b0, s, b);
            if (gaps && ($urandom % 4 == 0)) send_bit(1'b0, 1'b0, s, b);
          end
      end
    end
    idle(3);
  endtask

  task automatic cfg(input logic e1, input int c, input logic [7:0] m,
                     input logic re, input logic te, input string r);
    fmt_e1 = e1; code = c[4:0]; mask = m; rx_en = re; tx_en = te; cur_req = r;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (rx_stb !== 1'b0 || rx_bit !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: reset outputs actual %0b/%0b expected 0/0", rx_stb, rx_bit);
    end
    @(negedge clk); rst_n = 1'b1; run = 1'b1;
    idle(2);

    cfg(1'b1, 5, 8'hA5, 1'b1, 1'b1, "R1");  run_frames(2, 1'b0, 1'b0);
    cfg(1'b1, 0, 8'hFF, 1'b1, 1'b1, "R2");  run_frames(1, 1'b0, 1'b0);
    cfg(1'b1, 31, 8'h01, 1'b1, 1'b1, "R10"); run_frames(2, 1'b0, 1'b1);
    cfg(1'b1, 17, 8'h3C, 1'b1, 1'b1, "R4"); run_frames(1, 1'b0, 1'b0);
    cfg(1'b0, 0, 8'h00, 1'b1, 1'b1, "R3");  run_frames(4, 1'b0, 1'b0);
    cfg(1'b0, 24, 8'h80, 1'b1, 1'b1, "R4"); run_frames(2, 1'b0, 1'b0);
    cfg(1'b0, 3, 8'hFF, 1'b0, 1'b1, "R6");  run_frames(1, 1'b0, 1'b0);
    cfg(1'b0, 3, 8'hFF, 1'b1, 1'b0, "R8");  run_frames(1, 1'b0, 1'b0);
    cfg(1'b0, 0, 8'hFF, 1'b1, 1'b1, "R9");  run_frames(3, 1'b1, 1'b0);
    cfg(1'b1, 9, 8'h5A, 1'b1, 1'b1, "R9");  run_frames(2, 1'b1, 1'b0);
    cfg(1'b0, 30, 8'hFF, 1'b1, 1'b1, "R10"); run_frames(1, 1'b0, 1'b0);
    cfg(1'b0, 12, 8'h81, 1'b1, 1'b1, "R5"); run_frames(2, 1'b1, 1'b0);

    n_vec++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R5: pending rx items actual %0d expected 0", q.size());
    end
    run = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule